// File: doc/BRIEF.md
# I2C Target for a 16-bit Register Bank

This block lets a host on a two-wire serial bus read and write a small bank of 16-bit registers. It oversamples the clock and data lines with the system clock and detects start, repeated start and stop. It answers one 7-bit target address whose two low bits come from strap inputs. It releases or pulls down the data line through a single output-enable, so a pad or pull-up outside the block forms the open-drain wire.

Every register transfer is a pair of bytes, high byte first. A write names an 8-bit register pointer and then sends one or more pairs. A register is only stored once both bytes of its pair have arrived, and the pointer then steps forward. A read first sets the pointer with a write. After a repeated start with the read bit set, the block returns the high byte and then the low byte of the addressed register. A host acknowledge after a low byte moves on to the next register. A host not-acknowledge ends the read.

Top module: `i2c_reg16_target`

## Requirements
- R1: The block responds only to the address byte {5'b01101, strap_i[1], strap_i[0], rw}. On any other address it leaves SDA released for the rest of the transfer, so it acknowledges nothing and changes no register, until the next start or stop.
- R2: The block acknowledges a matching address byte, the pointer byte and every written data byte by holding sda_oe_o high for the ninth SCL clock. It changes sda_oe_o only while SCL is low.
- R3: In a write, the first data pair goes to the register at the pointer. Each later pair in the same transfer goes to the next pointer value.
- R4: A register changes only when both bytes of a pair have arrived. A stop after only the high byte of a pair leaves that register at its old value.
- R5: After a repeated start and an address byte with rw=1, the block sends the high byte and then the low byte of the register at the pointer, each MSB first. A 1 on the wire is sent by releasing SDA and a 0 by driving it.
- R6: A host acknowledge after a low byte advances the pointer by one, and the next register's high and low bytes follow. An acknowledge after a high byte does not advance the pointer.
- R7: After a host not-acknowledge, the block keeps SDA released until the host's stop.
- R8: The pointer is 8 bits and wraps from 0xFF to 0x00. A pointer value selects register (pointer mod NUM_REGS), with NUM_REGS = 16 by default.
- R9: After reset, every register reads 0x0000 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_i | input | 2 | Strap bits that form address bits 1 and 0 |
| scl_i | input | 1 | Serial clock as seen on the wire |
| sda_i | input | 1 | Serial data as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The hardest case is the pointer step at the end of a read pair. It only happens after a pointer write, a repeated start with the read bit set, and a host acknowledge after a low byte. The bench reaches it with multi-register reads, and one of them starts at pointer 0xFF so that the read also crosses the wrap. Several other conditions cannot be seen from a single byte: a half-written pair, a foreign address and a changed strap. For each of these the bench follows the transfer with a full read of the registers it could have touched.

// File: rtl/i2c_reg16_pkg.sv
`timescale 1ns/1ps
package i2c_reg16_pkg;

    localparam logic [4:0] DEV_ID = 5'b01101;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_ACK,
        S_TX,
        S_CHK,
        S_IGN
    } st_e;

    // meaning of the byte being received (or of the phase after it)
    typedef enum logic [2:0] {
        K_DEV,
        K_PTR,
        K_HI,
        K_LO,
        K_RD
    } kind_e;

    typedef struct packed {
        st_e         st;
        kind_e       kind;
        logic [3:0]  cnt;
        logic [7:0]  shf;
        logic [7:0]  ptr;
        logic [7:0]  hi;
        logic [15:0] word;
        logic        lo_sel;
        logic        hack;
        logic        oe;
        logic        wr;
        logic [7:0]  wptr;
        logic [15:0] wdat;
    } fsm_t;

endpackage

// File: rtl/i2c_reg16_sync.sv
`timescale 1ns/1ps
module i2c_reg16_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic [STAGES-1:0] scl_pipe_d, scl_pipe_q;
    logic [STAGES-1:0] sda_pipe_d, sda_pipe_q;
    logic              scl_last_d, scl_last_q;
    logic              sda_last_d, sda_last_q;

    always_comb begin
        scl_pipe_d = {scl_pipe_q[STAGES-2:0], scl_i};
        sda_pipe_d = {sda_pipe_q[STAGES-2:0], sda_i};
        scl_last_d = scl_pipe_q[STAGES-1];
        sda_last_d = sda_pipe_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe_q <= '1;
            sda_pipe_q <= '1;
            scl_last_q <= 1'b1;
            sda_last_q <= 1'b1;
        end else begin
            scl_pipe_q <= scl_pipe_d;
            sda_pipe_q <= sda_pipe_d;
            scl_last_q <= scl_last_d;
            sda_last_q <= sda_last_d;
        end
    end

    assign scl_o      = scl_pipe_q[STAGES-1];
    assign sda_o      = sda_pipe_q[STAGES-1];
    assign scl_rise_o = scl_o & ~scl_last_q;
    assign scl_fall_o = ~scl_o & scl_last_q;
    assign start_o    = scl_o & scl_last_q & sda_last_q & ~sda_o;
    assign stop_o     = scl_o & scl_last_q & ~sda_last_q & sda_o;

endmodule

// File: rtl/i2c_reg16_bank.sv
`timescale 1ns/1ps
module i2c_reg16_bank #(
    parameter int NUM_REGS = 16,
    parameter int WIDTH    = 16,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem_d [NUM_REGS];
    logic [WIDTH-1:0] mem_q [NUM_REGS];

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en) begin
            mem_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/i2c_reg16_fsm.sv
`timescale 1ns/1ps
module i2c_reg16_fsm
    import i2c_reg16_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  strap_i,
    input  logic        scl_s,
    input  logic        sda_s,
    input  logic        scl_rise,
    input  logic        scl_fall,
    input  logic        start,
    input  logic        stop,
    input  logic [15:0] rd_data,
    output logic [7:0]  rd_ptr,
    output logic        wr_en,
    output logic [7:0]  wr_ptr,
    output logic [15:0] wr_data,
    output logic        sda_oe
);

    fsm_t       r_d, r_q;
    logic [7:0] cur;

    always_comb begin
        r_d    = r_q;
        r_d.wr = 1'b0;
        cur    = r_q.lo_sel ? r_q.word[7:0] : r_q.word[15:8];

        if (stop) begin
            r_d.st = S_IDLE;
            r_d.oe = 1'b0;
        end else if (start) begin
            r_d.st   = S_RX;
            r_d.kind = K_DEV;
            r_d.cnt  = 4'd0;
            r_d.oe   = 1'b0;
        end else begin
            case (r_q.st)
                S_RX: begin
                    if (scl_rise && r_q.cnt < 4'd8) begin
                        r_d.shf = {r_q.shf[6:0], sda_s};
                        r_d.cnt = r_q.cnt + 4'd1;
                    end else if (scl_fall && r_q.cnt == 4'd8) begin
                        r_d.cnt = 4'd0;
                        r_d.st  = S_ACK;
                        r_d.oe  = 1'b1;
                        case (r_q.kind)
                            K_DEV: begin
                                if (r_q.shf[7:1] == {DEV_ID, strap_i}) begin
                                    r_d.kind = r_q.shf[0] ? K_RD : K_PTR;
                                end else begin
                                    r_d.st = S_IGN;
                                    r_d.oe = 1'b0;
                                end
                            end
                            K_PTR: begin
                                r_d.ptr  = r_q.shf;
                                r_d.kind = K_HI;
                            end
                            K_HI: begin
                                r_d.hi   = r_q.shf;
                                r_d.kind = K_LO;
                            end
                            K_LO: begin
                                r_d.wr   = 1'b1;
                                r_d.wptr = r_q.ptr;
                                r_d.wdat = {r_q.hi, r_q.shf};
                                r_d.ptr  = r_q.ptr + 8'd1;
                                r_d.kind = K_HI;
                            end
                            default: begin
                                r_d.st = S_IGN;
                                r_d.oe = 1'b0;
                            end
                        endcase
                    end
                end
                S_ACK: begin
                    if (scl_fall) begin
                        r_d.oe = 1'b0;
                        if (r_q.kind == K_RD) begin
                            r_d.word   = rd_data;
                            r_d.lo_sel = 1'b0;
                            r_d.oe     = ~rd_data[15];
                            r_d.cnt    = 4'd1;
                            r_d.st     = S_TX;
                        end else begin
                            r_d.cnt = 4'd0;
                            r_d.st  = S_RX;
                        end
                    end
                end
                S_TX: begin
                    if (scl_fall) begin
                        if (r_q.cnt == 4'd8) begin
                            r_d.st  = S_CHK;
                            r_d.oe  = 1'b0;
                            r_d.cnt = 4'd0;
                        end else begin
                            r_d.oe  = ~cur[3'd7 - r_q.cnt[2:0]];
                            r_d.cnt = r_q.cnt + 4'd1;
                        end
                    end
                end
                S_CHK: begin
                    if (scl_rise) begin
                        r_d.hack = ~sda_s;
                        if (~sda_s && r_q.lo_sel) begin
                            r_d.ptr = r_q.ptr + 8'd1;
                        end
                    end else if (scl_fall) begin
                        if (r_q.hack) begin
                            r_d.st  = S_TX;
                            r_d.cnt = 4'd1;
                            if (!r_q.lo_sel) begin
                                r_d.lo_sel = 1'b1;
                                r_d.oe     = ~r_q.word[7];
                            end else begin
                                r_d.word   = rd_data;
                                r_d.lo_sel = 1'b0;
                                r_d.oe     = ~rd_data[15];
                            end
                        end else begin
                            r_d.st = S_IGN;
                            r_d.oe = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= S_IDLE;
            r_q.kind <= K_DEV;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_ptr  = r_q.ptr;
    assign wr_en   = r_q.wr;
    assign wr_ptr  = r_q.wptr;
    assign wr_data = r_q.wdat;
    assign sda_oe  = r_q.oe;

    // R1
    ign_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_IGN || r_q.st == S_IDLE) |-> !r_q.oe);

    // R2
    sda_change_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.oe != $past(r_q.oe)) && !$past(start || stop)) |-> !scl_s);

    // R3, R8
    pair_ptr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.wr |-> (r_q.ptr == r_q.wptr + 8'd1));

    // R6
    rd_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_CHK && r_q.ptr != $past(r_q.ptr)) |-> r_q.lo_sel);

    // R7
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !r_q.oe);

endmodule

// File: rtl/i2c_reg16_target.sv
`timescale 1ns/1ps
module i2c_reg16_target #(
    parameter int NUM_REGS    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] strap_i,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o
);

    localparam int IDX_W = $clog2(NUM_REGS);

    logic        scl_s, sda_s, scl_rise, scl_fall, start, stop;
    logic [7:0]  rd_ptr, wr_ptr;
    logic        wr_en;
    logic [15:0] wr_data, rd_data;

    i2c_reg16_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start),
        .stop_o     (stop)
    );

    i2c_reg16_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap_i  (strap_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start    (start),
        .stop     (stop),
        .rd_data  (rd_data),
        .rd_ptr   (rd_ptr),
        .wr_en    (wr_en),
        .wr_ptr   (wr_ptr),
        .wr_data  (wr_data),
        .sda_oe   (sda_oe_o)
    );

    i2c_reg16_bank #(.NUM_REGS(NUM_REGS), .WIDTH(16)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_ptr[IDX_W-1:0]),
        .wr_data (wr_data),
        .rd_idx  (rd_ptr[IDX_W-1:0]),
        .rd_data (rd_data)
    );

endmodule

// File: tb/test_i2c_reg16_target.sv
`timescale 1ns/1ps
module test_i2c_reg16_target;

    localparam int Q = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_h = 1'b1;
    logic [1:0] strap = 2'b01;
    logic       sda_oe;
    logic       sda_line;

    int n_chk  = 0;
    int n_fail = 0;

    logic [15:0] mdl [16];
    logic [7:0]  exp_q [$];
    string       tag_q [$];
    logic [7:0]  obs_q [$];

    assign sda_line = sda_h & ~sda_oe;

    always #2.5 clk = ~clk;

    i2c_reg16_target i_i2c_reg16_target (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap_i  (strap),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe)
    );

    task automatic wq(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] abyte(input logic [1:0] s, input logic rw);
        return {5'b01101, s, rw};
    endfunction

    task automatic bus_start();
        sda_h = 1'b1; wq(Q);
        scl = 1'b1;   wq(Q);
        sda_h = 1'b0; wq(Q);
        scl = 1'b0;   wq(Q);
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; wq(Q);
        scl = 1'b1;   wq(Q);
        sda_h = 1'b1; wq(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_h = b[i]; wq(Q);
            scl = 1'b1;   wq(2*Q);
            scl = 1'b0;   wq(Q);
        end
        sda_h = 1'b1; wq(Q);
        scl = 1'b1;   wq(Q);
        ack = ~sda_line;
        wq(Q);
        scl = 1'b0;   wq(Q);
    endtask

    task automatic recv_byte(input bit nack);
        logic [7:0] b;
        sda_h = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q);
            scl = 1'b1; wq(Q);
            b[i] = sda_line;
            wq(Q);
            scl = 1'b0; wq(Q);
        end
        obs_q.push_back(b);
        sda_h = nack; wq(Q);
        scl = 1'b1;   wq(2*Q);
        scl = 1'b0;   wq(Q);
        sda_h = 1'b1;
    endtask

    task automatic expect_word(input logic [15:0] w, input string tag);
        exp_q.push_back(w[15:8]); tag_q.push_back(tag);
        exp_q.push_back(w[7:0]);  tag_q.push_back(tag);
    endtask

    // write n pairs (1 or 2) starting at ptr, checking every acknowledge
    task automatic write_seq(input logic [7:0] ptr, input logic [15:0] w0,
                             input logic [15:0] w1, input int n, input string tag);
        bit ack;
        bus_start();
        send_byte(abyte(strap, 1'b0), ack); check(ack, {"R2 addr ", tag}, ack, 1);
        send_byte(ptr, ack);                check(ack, {"R2 ptr ", tag}, ack, 1);
        send_byte(w0[15:8], ack);           check(ack, {"R2 hi ", tag}, ack, 1);
        send_byte(w0[7:0], ack);            check(ack, {"R2 lo ", tag}, ack, 1);
        mdl[ptr[3:0]] = w0;
        if (n > 1) begin
            send_byte(w1[15:8], ack); check(ack, {"R2 hi2 ", tag}, ack, 1);
            send_byte(w1[7:0], ack);  check(ack, {"R2 lo2 ", tag}, ack, 1);
            mdl[4'(ptr[3:0] + 4'd1)] = w1;
        end
        bus_stop();
    endtask

    task automatic read_seq(input logic [7:0] ptr, input int n, input string tag);
        bit ack;
        bus_start();
        send_byte(abyte(strap, 1'b0), ack); check(ack, {"R2 raddr ", tag}, ack, 1);
        send_byte(ptr, ack);                check(ack, {"R2 rptr ", tag}, ack, 1);
        bus_start();
        send_byte(abyte(strap, 1'b1), ack); check(ack, {"R5 addr ", tag}, ack, 1);
        for (int i = 0; i < n; i++) begin
            expect_word(mdl[4'(ptr[3:0] + 4'(i))], tag);
            recv_byte(1'b0);
            recv_byte(i == n - 1);
        end
        wq(2*Q);
        check(sda_oe == 1'b0, {"R7 release ", tag}, sda_oe, 0);
        bus_stop();
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(posedge clk);
            while (obs_q.size() > 0 && exp_q.size() > 0) begin
                logic [7:0] o, e;
                string t;
                o = obs_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_chk++;
                if (o !== e) begin
                    n_fail++;
                    $display("FAIL %s read byte: actual %0h expected %0h", t, o, e);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit ack;
        for (int i = 0; i < 16; i++) mdl[i] = 16'h0000;
        wq(5);
        rst_n = 1'b1;
        wq(5);
        // R9 reset state
        check(sda_oe == 1'b0, "R9 sda released", sda_oe, 0);
        read_seq(8'h09, 1, "R9 reset reg");

        // R3 R5 R6: two pairs, then read both with pointer advance
        write_seq(8'h02, 16'hA55A, 16'h1234, 2, "R3");
        read_seq(8'h02, 2, "R5 R6");
        read_seq(8'h03, 1, "R3 second pair");

        // R1: foreign address is ignored
        bus_start();
        send_byte(abyte(2'b10, 1'b0), ack); check(!ack, "R1 no ack addr", ack, 0);
        send_byte(8'h02, ack);              check(!ack, "R1 no ack ptr", ack, 0);
        send_byte(8'hFF, ack);              check(!ack, "R1 no ack hi", ack, 0);
        send_byte(8'hFF, ack);              check(!ack, "R1 no ack lo", ack, 0);
        bus_stop();
        read_seq(8'h02, 1, "R1 reg unchanged");

        // R1: new strap value moves the address
        strap = 2'b10;
        wq(4);
        write_seq(8'h06, 16'h0F0F, 16'h0000, 1, "R1 strap");
        read_seq(8'h06, 1, "R1 strap read");

        // R4: pair then lone high byte, then stop
        bus_start();
        send_byte(abyte(strap, 1'b0), ack); check(ack, "R4 addr", ack, 1);
        send_byte(8'h07, ack);              check(ack, "R4 ptr", ack, 1);
        send_byte(8'h5A, ack);              check(ack, "R4 hi", ack, 1);
        send_byte(8'hC3, ack);              check(ack, "R4 lo", ack, 1);
        mdl[7] = 16'h5AC3;
        send_byte(8'h99, ack);              check(ack, "R4 lone hi", ack, 1);
        bus_stop();
        read_seq(8'h07, 2, "R4 partial pair");

        // R8: pointer wrap in write and in read
        write_seq(8'hFF, 16'hBEEF, 16'hCAFE, 2, "R8 wrap");
        read_seq(8'hFF, 2, "R8 wrap read");
        read_seq(8'h00, 1, "R8 reg0");

        // R6: three-register read burst
        read_seq(8'h01, 3, "R6 burst");

        wq(200);
        check(exp_q.size() == 0, "R5 queue drained", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule